// File: doc/BRIEF.md
# Variable-Period Test Clock Sequencer

This block applies test vectors to a circuit under test and generates a test clock whose period may change from one vector to the next. Four clock periods are held in configuration inputs, each counted in cycles of a fast reference clock. Every vector arrives on a ready/valid stream. It carries a pattern word for the primary inputs, one serial scan bit and a two-bit period code. Instead of the code, a vector may carry a required period length. The block then uses the shortest programmed period that still covers that length.

For each accepted vector the block drives the primary inputs and the scan bit at the first count of the period. It holds the test clock low for the first half of the period and high for the second half. On the last reference cycle it captures the response of the circuit under test. The captured word and the code that was actually used are presented on a one-cycle output strobe in the following cycle. A synchronous mode forces every vector onto the longest programmed period. A programmed floor stops any period from being shorter than the critical-path limit. A free-running tally of reference cycles spent in periods lets a synchronous run be compared with a variable-period run.

The controller has two states. IDLE has no period in progress. RUN means a period is counting. The transition IDLE to RUN happens when a vector is accepted. RUN to RUN happens on every cycle of a period, and also when the last cycle of one period accepts the next vector (back-to-back). RUN to IDLE happens on the last cycle of a period when no vector is valid.

Top module: `vp_test_clock_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, vec_ready is 1, cut_tck is 0, rsp_valid is 0, total_cycles is 0, and cut_pi and cut_scan_in are 0.
- R2: With cfg_sync_mode=0 and vec_by_req=0, a vector uses the period in cfg_period[vec_code], where code 0 to 3 indexes the four entries.
- R3: A period of P reference cycles has cut_tck low for counts 0 to P/2-1 and high for counts P/2 to P-1. This gives exactly P/2 high and P/2 low cycles.
- R4: cut_pi and cut_scan_in take the accepted vector's values in count 0 of its period, the cycle after acceptance. They stay unchanged through the period, so they lead the rising clock edge by P/2 cycles.
- R5: On the last cycle of a period cut_resp is captured. In the next cycle rsp_valid is 1 for one cycle, with rsp_data equal to the captured word and rsp_code equal to the code that set the period.
- R6: vec_ready is 1 in IDLE and on the last cycle of a period, and 0 on every other cycle of a period. A vector valid on that last cycle starts its count 0 in the very next cycle, with no idle cycle.
- R7: With vec_by_req=1 (and sync mode off), the chosen code is the one whose programmed period is the smallest value not less than vec_req_period. The lowest code wins among equal values.
- R8: With vec_by_req=1 and vec_req_period above every programmed period, the code of the longest programmed period is chosen.
- R9: With cfg_sync_mode=1, every vector uses the code of the longest programmed period (lowest code on a tie), whatever its code or required period.
- R10: The period actually run is the chosen programmed value, raised to cfg_min_period if shorter, raised to 4 if shorter, then raised by one if odd.
- R11: total_cycles increases by exactly one on every reference cycle spent inside a period and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 4 x CNT_W | Four programmed periods in reference cycles, indexed by code |
| cfg_min_period | input | CNT_W | Floor applied to every period |
| cfg_sync_mode | input | 1 | 1 forces the longest programmed period |
| vec_valid | input | 1 | Vector stream valid |
| vec_ready | output | 1 | Vector stream ready |
| vec_pattern | input | PAT_W | Primary input pattern |
| vec_scan_bit | input | 1 | Serial scan bit for this test cycle |
| vec_code | input | 2 | Period code |
| vec_by_req | input | 1 | 1 selects the period from vec_req_period |
| vec_req_period | input | CNT_W | Required period to be rounded up |
| cut_pi | output | PAT_W | Primary inputs to the circuit under test |
| cut_scan_in | output | 1 | Scan-in bit to the circuit under test |
| cut_tck | output | 1 | Test clock |
| cut_resp | input | RSP_W | Response from the circuit under test |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | RSP_W | Captured response |
| rsp_code | output | 2 | Code that set the period of this response |
| total_cycles | output | TOT_W | Reference cycles spent in periods |

## Verification
The hardest case to reach from the ports is a vector handshake on the final cycle of a period. The stream must be valid at that cycle so the clock falls and the new inputs land on the same edge, with no idle cycle. The bench reaches it by issuing the next vector from the same falling-edge slot in which the previous one was accepted. That keeps valid high through the whole stall, so the handshake lands on the last count. Floor clamping and odd rounding are reached by reprogramming the floor between vectors. The resulting high-time length is then measured at the clock pin.

// File: rtl/vps_pkg.sv
package vps_pkg;
    localparam int NUM_PERIODS = 4;
    localparam int CODE_W      = $clog2(NUM_PERIODS);
    localparam int MIN_TICKS   = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vps_state_e;
endpackage

// File: rtl/vps_period_select.sv
module vps_period_select
    import vps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [NUM_PERIODS-1:0][CNT_W-1:0] periods,
    input  logic [CNT_W-1:0]                  floor_ticks,
    input  logic                              sync_mode,
    input  logic                              by_req,
    input  logic [CNT_W-1:0]                  req_ticks,
    input  logic [CODE_W-1:0]                 code_in,
    output logic [CODE_W-1:0]                 code_out,
    output logic [CNT_W:0]                    eff_ticks
);
    localparam int PW = CNT_W + 1;

    logic [CODE_W-1:0] longest_idx;
    logic [CODE_W-1:0] fit_idx;
    logic              fit_found;
    logic [CNT_W-1:0]  raw;
    logic [CNT_W-1:0]  lifted;
    logic [CNT_W-1:0]  floored;

    // longest programmed period, lowest index on a tie
    always_comb begin
        longest_idx = '0;
        for (int i = 1; i < NUM_PERIODS; i++) begin
            if (periods[i] > periods[longest_idx]) longest_idx = CODE_W'(i);
        end
    end

    // shortest programmed period covering the required length
    always_comb begin
        fit_idx   = '0;
        fit_found = 1'b0;
        for (int i = 0; i < NUM_PERIODS; i++) begin
            if (periods[i] >= req_ticks &&
                (!fit_found || periods[i] < periods[fit_idx])) begin
                fit_idx   = CODE_W'(i);
                fit_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (sync_mode)      code_out = longest_idx;
        else if (!by_req)   code_out = code_in;
        else if (fit_found) code_out = fit_idx;
        else                code_out = longest_idx;
    end

    assign raw     = periods[code_out];
    assign lifted  = (raw < floor_ticks) ? floor_ticks : raw;
    assign floored = (lifted < CNT_W'(MIN_TICKS)) ? CNT_W'(MIN_TICKS) : lifted;
    assign eff_ticks = PW'(floored) + PW'(floored[0]);
endmodule

// File: rtl/vps_cycle_tally.sv
module vps_cycle_tally #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [TOT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)  count <= '0;
        else if (en) count <= count + TOT_W'(1);
    end
endmodule

// File: rtl/vp_test_clock_seq.sv
module vp_test_clock_seq
    import vps_pkg::*;
#(
    parameter int PAT_W = 8,
    parameter int RSP_W = 8,
    parameter int CNT_W = 8,
    parameter int TOT_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PERIODS-1:0][CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0]                  cfg_min_period,
    input  logic                              cfg_sync_mode,
    input  logic                              vec_valid,
    output logic                              vec_ready,
    input  logic [PAT_W-1:0]                  vec_pattern,
    input  logic                              vec_scan_bit,
    input  logic [CODE_W-1:0]                 vec_code,
    input  logic                              vec_by_req,
    input  logic [CNT_W-1:0]                  vec_req_period,
    output logic [PAT_W-1:0]                  cut_pi,
    output logic                              cut_scan_in,
    output logic                              cut_tck,
    input  logic [RSP_W-1:0]                  cut_resp,
    output logic                              rsp_valid,
    output logic [RSP_W-1:0]                  rsp_data,
    output logic [CODE_W-1:0]                 rsp_code,
    output logic [TOT_W-1:0]                  total_cycles
);
    localparam int PW = CNT_W + 1;

    vps_state_e        state_q, state_d;
    logic [PW-1:0]     cnt_q;
    logic [PW-1:0]     per_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] sel_code;
    logic [PW-1:0]     sel_ticks;
    logic              last_tick;
    logic              accept;

    vps_period_select #(.CNT_W(CNT_W)) u_sel (
        .periods     (cfg_period),
        .floor_ticks (cfg_min_period),
        .sync_mode   (cfg_sync_mode),
        .by_req      (vec_by_req),
        .req_ticks   (vec_req_period),
        .code_in     (vec_code),
        .code_out    (sel_code),
        .eff_ticks   (sel_ticks)
    );

    vps_cycle_tally #(.TOT_W(TOT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_RUN),
        .count (total_cycles)
    );

    assign last_tick = (state_q == ST_RUN) && (cnt_q == per_q - PW'(1));
    assign accept    = vec_valid && vec_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (last_tick && !accept) state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        vec_ready = 1'b0;
        cut_tck   = 1'b0;
        unique case (state_q)
            ST_IDLE: vec_ready = 1'b1;
            ST_RUN: begin
                vec_ready = last_tick;
                cut_tck   = (cnt_q >= (per_q >> 1));
            end
        endcase
    end

    // period datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            per_q       <= PW'(MIN_TICKS);
            code_q      <= '0;
            cut_pi      <= '0;
            cut_scan_in <= 1'b0;
        end else if (accept) begin
            cnt_q       <= '0;
            per_q       <= sel_ticks;
            code_q      <= sel_code;
            cut_pi      <= vec_pattern;
            cut_scan_in <= vec_scan_bit;
        end else if (state_q == ST_RUN) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    // response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_code  <= '0;
        end else begin
            rsp_valid <= last_tick;
            if (last_tick) begin
                rsp_data <= cut_resp;
                rsp_code <= code_q;
            end
        end
    end
endmodule

// File: rtl/vp_seq_chk.sv
module vp_seq_chk #(
    parameter int PAT_W = 8,
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_ready,
    input logic             cut_tck,
    input logic [PAT_W-1:0] cut_pi,
    input logic             rsp_valid,
    input logic [TOT_W-1:0] total_cycles
);
    // R6
    ready_low_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_tck) |-> !vec_ready);

    // R3
    high_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_tck) |=> cut_tck);

    // R4
    pi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_tck && $past(cut_tck)) |-> $stable(cut_pi));

    // R5
    rsp_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cut_tck));

    // R11
    tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cut_tck) |-> (total_cycles == $past(total_cycles) + TOT_W'(1)));
endmodule

bind vp_test_clock_seq vp_seq_chk #(.PAT_W(PAT_W), .TOT_W(TOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_ready    (vec_ready),
    .cut_tck      (cut_tck),
    .cut_pi       (cut_pi),
    .rsp_valid    (rsp_valid),
    .total_cycles (total_cycles)
);

// File: tb/sim_vp_test_clock_seq.sv
`timescale 1ns/1ps
module sim_vp_test_clock_seq;
    localparam int PAT_W = 8, RSP_W = 8, CNT_W = 8, TOT_W = 32;

    logic clk = 0, rst_n = 0;
    logic [3:0][CNT_W-1:0] cfg_period;
    logic [CNT_W-1:0] cfg_min_period = 4;
    logic cfg_sync_mode = 0;
    logic vec_valid = 0, vec_ready, vec_scan_bit = 0, vec_by_req = 0;
    logic [PAT_W-1:0] vec_pattern = 0;
    logic [1:0] vec_code = 0;
    logic [CNT_W-1:0] vec_req_period = 0;
    logic [PAT_W-1:0] cut_pi;
    logic cut_scan_in, cut_tck, rsp_valid;
    logic [RSP_W-1:0] cut_resp = 0, rsp_data;
    logic [1:0] rsp_code;
    logic [TOT_W-1:0] total_cycles;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vp_test_clock_seq #(.PAT_W(PAT_W), .RSP_W(RSP_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_min_period(cfg_min_period),
        .cfg_sync_mode(cfg_sync_mode), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .vec_pattern(vec_pattern), .vec_scan_bit(vec_scan_bit), .vec_code(vec_code),
        .vec_by_req(vec_by_req), .vec_req_period(vec_req_period), .cut_pi(cut_pi),
        .cut_scan_in(cut_scan_in), .cut_tck(cut_tck), .cut_resp(cut_resp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_code(rsp_code),
        .total_cycles(total_cycles));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_busy = 0, m_cnt = 0, m_per = 4, m_code = 0, m_pat = 0, m_sb = 0;
    int m_total = 0, m_rv = 0, m_rd = 0, m_rcode = 0;

    function automatic int longest_code();
        int b = 0;
        for (int i = 1; i < 4; i++) if (int'(cfg_period[i]) > int'(cfg_period[b])) b = i;
        return b;
    endfunction

    function automatic int pick_code();
        int b = -1;
        if (cfg_sync_mode) return longest_code();
        if (!vec_by_req) return int'(vec_code);
        for (int i = 0; i < 4; i++)
            if (int'(cfg_period[i]) >= int'(vec_req_period) &&
                (b < 0 || int'(cfg_period[i]) < int'(cfg_period[b]))) b = i;
        return (b < 0) ? longest_code() : b;
    endfunction

    function automatic int run_len(input int c);
        int m = int'(cfg_period[c]);
        if (int'(cfg_min_period) > m) m = int'(cfg_min_period);
        if (m < 4) m = 4;
        if (m % 2 == 1) m++;
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_per = 4; m_code = 0; m_pat = 0; m_sb = 0;
            m_total = 0; m_rv = 0; m_rd = 0; m_rcode = 0;
        end else begin
            int rdy;
            rdy  = (!m_busy || m_cnt == m_per - 1) ? 1 : 0;
            m_rv = 0;
            if (m_busy) begin
                m_total++;
                if (m_cnt == m_per - 1) begin
                    m_rv = 1; m_rd = int'(cut_resp); m_rcode = m_code; m_busy = 0;
                end else m_cnt++;
            end
            if (vec_valid && rdy) begin
                m_code = pick_code(); m_per = run_len(m_code);
                m_busy = 1; m_cnt = 0; m_pat = int'(vec_pattern); m_sb = int'(vec_scan_bit);
            end
        end
    end

    // per-clock comparison and clock-pin monitor
    int hi_cnt = 0, last_hi = 0, last_code = 0, rsp_seen = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            int e_tck, e_rdy;
            e_tck = (m_busy && m_cnt >= m_per / 2) ? 1 : 0;
            e_rdy = (!m_busy || m_cnt == m_per - 1) ? 1 : 0;
            check(int'(cut_tck) == e_tck, "R3 tck", cut_tck, e_tck);
            check(int'(vec_ready) == e_rdy, "R6 ready", vec_ready, e_rdy);
            check(int'(cut_pi) == m_pat && int'(cut_scan_in) == m_sb, "R4 pi",
                  cut_pi, m_pat);
            check(int'(rsp_valid) == m_rv, "R5 valid", rsp_valid, m_rv);
            if (m_rv == 1) begin
                check(int'(rsp_data) == m_rd, "R5 data", rsp_data, m_rd);
                check(int'(rsp_code) == m_rcode, "R5 code", rsp_code, m_rcode);
            end
            check(total_cycles == TOT_W'(m_total), "R11 total", total_cycles, m_total);
            if (cut_tck) hi_cnt++;
            else if (hi_cnt > 0) begin last_hi = hi_cnt; hi_cnt = 0; end
            if (rsp_valid) begin last_code = int'(rsp_code); rsp_seen++; end
        end
        cut_resp <= 8'(cyc * 37) ^ cut_pi;
    end

    task automatic send(input int pat, input int sb, input int code, input int br, input int req);
        vec_valid = 1; vec_pattern = 8'(pat); vec_scan_bit = 1'(sb);
        vec_code = 2'(code); vec_by_req = 1'(br); vec_req_period = 8'(req);
        while (!vec_ready) @(negedge clk);
        @(negedge clk);
        vec_valid = 0;
    endtask

    task automatic drain();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic one(input int code, input int br, input int req,
                       input int exp_hi, input int exp_code, input string tag);
        send(8'hA5 ^ code, code & 1, code, br, req);
        drain();
        check(last_hi == exp_hi, {tag, " high"}, last_hi, exp_hi);
        check(last_code == exp_code, {tag, " code"}, last_code, exp_code);
    endtask

    initial begin
        cfg_period[0] = 6; cfg_period[1] = 10; cfg_period[2] = 4; cfg_period[3] = 16;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(vec_ready == 1 && cut_tck == 0 && rsp_valid == 0, "R1 flags",
              {vec_ready, cut_tck, rsp_valid}, 3'b100);
        check(total_cycles == 0 && cut_pi == 0 && cut_scan_in == 0, "R1 data",
              total_cycles, 0);
        rst_n = 1;
        @(negedge clk);
        check(vec_ready == 1 && cut_tck == 0 && total_cycles == 0, "R1 after",
              total_cycles, 0);
        // R2 direct codes
        one(1, 0, 0, 5, 1, "R2 c1");
        one(2, 0, 0, 2, 2, "R2 c2");
        one(3, 0, 0, 8, 3, "R2 c3");
        one(0, 0, 0, 3, 0, "R2 c0");
        // R7 round up
        one(0, 1, 7, 5, 1, "R7 req7");
        one(0, 1, 10, 5, 1, "R7 req10");
        one(0, 1, 3, 2, 2, "R7 req3");
        // R8 above all
        one(0, 1, 20, 8, 3, "R8 req20");
        // R9 sync mode
        cfg_sync_mode = 1;
        one(0, 0, 0, 8, 3, "R9 sync c0");
        one(2, 1, 3, 8, 3, "R9 sync req");
        cfg_sync_mode = 0;
        // R10 floor and odd rounding
        cfg_min_period = 12;
        one(0, 0, 0, 6, 0, "R10 floor12");
        cfg_min_period = 9;
        one(2, 0, 0, 5, 2, "R10 odd9");
        cfg_min_period = 4;
        cfg_period[2] = 5;
        one(2, 0, 0, 3, 2, "R10 odd5");
        cfg_period[2] = 2;
        one(2, 0, 0, 2, 2, "R10 min4");
        cfg_period[2] = 4;
        // R11 tally over one code-1 vector
        begin
            int t0;
            t0 = int'(total_cycles);
            one(1, 0, 0, 5, 1, "R11 step");
            check(int'(total_cycles) == t0 + 10, "R11 delta", total_cycles, t0 + 10);
        end
        // R6 back-to-back vectors: no idle between periods
        begin
            int n0;
            n0 = rsp_seen;
            for (int k = 0; k < 6; k++) send(k * 17, k & 1, k % 4, 0, 0);
            drain();
            check(rsp_seen == n0 + 6, "R6 count", rsp_seen - n0, 6);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule